// File: doc/BRIEF.md
# SPI Controller with In-Band Command Words

This block is an SPI bus controller fed by one transmit queue in which every entry is tagged as either a command word or a 32-bit data word. A command word is decoded when it is popped and sets up the frames that follow: the frame length in bits, the shift direction, 32-bit byte reversal, whether received bits are kept, whether transmit data is drawn at all, and whether chip select stays low once the frame ends. Because the settings travel in the same stream as the data, each change lands exactly between the words it belongs between. A single chip select can stay low across many frames and many commands.

Each command that opens a frame shifts a frame of the programmed length on SCLK, MOSI and MISO in mode 0. A frame is cut into 32-bit pieces, and each piece consumes one data word and produces one receive word. Received words go into a small internal queue that is read with a valid/ready handshake. The SCLK rate is set by a static divider input. The shifting stalls without glitches when the transmit queue runs dry or the receive queue fills.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o and mosi_o are low, and rx_valid_o is low.
- R2: A queue entry with tx_is_cmd_i high is a command. It is decoded as it is popped: bits [11:0] give the frame length in bits, where any value below 8 is treated as 8; bit 16 selects LSB-first; bit 17 selects byte swap; bit 18 masks receive; bit 19 masks transmit; bit 20 keeps chip select low after the frame; bit 21 marks continuation. Unless R7 makes it a closing command, a command pulls cs_n_o low and opens exactly one frame.
- R3: A piece of b bits (1 to 32) sends bits b-1 down to 0 of its data word when MSB-first, or bits 0 up to b-1 when LSB-first. The first received bit lands in bit b-1 (MSB-first) or in bit 0 (LSB-first). The receive bits above b-1 read zero.
- R4: With byte swap set, the four bytes of each transmit word are reversed before the piece is selected, and each receive word is byte-reversed before it is queued.
- R5: With receive mask set, nothing is written to the receive queue for that frame.
- R6: With transmit mask set, no data word is popped during the frame, MOSI stays low, and MISO is still sampled.
- R7: When bit 20 is set, cs_n_o stays low after the frame. While chip select is held this way, a command with bit 21 set opens its frame without raising cs_n_o. A command with bit 21 clear only raises cs_n_o: it stores its settings and opens no frame.
- R8: A frame longer than 32 bits is shifted as full 32-bit pieces followed by one final partial piece. Each piece consumes one data word and produces one receive entry, and cs_n_o stays low between the pieces.
- R9: If a piece needs data and none is queued, SCLK stays low and cs_n_o stays low until a data word arrives. The frame then resumes without losing or repeating any bit.
- R10: A piece that would write the receive queue does not start while that queue is full. The queue never overflows.
- R11: SCLK is low while idle, and its period is 2*(div_i+1) clock cycles. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge of SCLK.
- R12: A data word at the head of the transmit queue while no frame is open is popped and dropped.
- R13: While rx_valid_o is high and rx_ready_i is low, rx_valid_o and rx_data_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | 8 | Static divider: SCLK period is 2*(div_i+1) clocks |
| tx_valid_i | input | 1 | A transmit queue entry is offered |
| tx_is_cmd_i | input | 1 | The offered entry is a command word |
| tx_data_i | input | 32 | Command or data word |
| tx_ready_o | output | 1 | The offered entry is popped at this clock edge |
| rx_valid_o | output | 1 | A receive word is available |
| rx_data_o | output | 32 | Oldest receive word |
| rx_ready_i | input | 1 | Consumer takes the receive word |
| sclk_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
The main shifting path is run with 8-, 12-, 16-, 32- and 40-bit frames in both bit orders, with byte swap on and off, and with an under-size length. These cases separate a wrong piece selection, a reversed shift direction, a misplaced receive bit and a swap applied on only one side. Masked frames show whether data is popped or written when it should not be. A held transfer followed by a closing command shows whether chip select rises too early, too late or not at all. Stalls on an empty transmit queue and on a full receive queue check that the bit stream is resumed exactly where it stopped.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int WORD_W = 32;
  localparam int FS_W   = 12;
  localparam int MIN_FS = 8;

  localparam int B_LSB   = 16;
  localparam int B_SWAP  = 17;
  localparam int B_RXMSK = 18;
  localparam int B_TXMSK = 19;
  localparam int B_HOLD  = 20;
  localparam int B_CONTG = 21;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WORD  = 2'd1,
    ST_SHIFT = 2'd2
  } spi_st_e;

  typedef struct packed {
    logic [FS_W-1:0] fsize;
    logic            lsb;
    logic            swap;
    logic            rx_mask;
    logic            tx_mask;
    logic            hold;
    logic            contg;
  } spi_cfg_t;

  localparam spi_cfg_t CFG_RST = '{fsize: FS_W'(MIN_FS), default: 1'b0};

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic spi_cfg_t cmd_decode(input logic [WORD_W-1:0] w);
    spi_cfg_t c;
    c.fsize   = (w[FS_W-1:0] < FS_W'(MIN_FS)) ? FS_W'(MIN_FS) : w[FS_W-1:0];
    c.lsb     = w[B_LSB];
    c.swap    = w[B_SWAP];
    c.rx_mask = w[B_RXMSK];
    c.tx_mask = w[B_TXMSK];
    c.hold    = w[B_HOLD];
    c.contg   = w[B_CONTG];
    return c;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == div_i);

  always_comb begin
    if (clr_i || !en_i || tick_o) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int W     = 32,
  parameter int DIV_W = 8,
  localparam int CW   = $clog2(W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [W-1:0]     word_i,
  input  logic [CW-1:0]    nbits_i,
  input  logic             lsb_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [W-1:0]     rx_o
);

  logic          busy_q, busy_d;
  logic          sclk_q, sclk_d;
  logic          lsb_q, lsb_d;
  logic [CW-1:0] left_q, left_d;
  logic [CW-1:0] nb_q, nb_d;
  logic [W-1:0]  tsh_q, tsh_d;
  logic [W-1:0]  rsh_q, rsh_d;
  logic          tick;

  spi_half_tick #(.DIV_W(DIV_W)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (busy_q),
    .clr_i  (start_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    lsb_d  = lsb_q;
    left_d = left_q;
    nb_d   = nb_q;
    tsh_d  = tsh_q;
    rsh_d  = rsh_q;
    if (start_i) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      lsb_d  = lsb_i;
      left_d = nbits_i;
      nb_d   = nbits_i;
      tsh_d  = lsb_i ? word_i : (word_i << (CW'(W) - nbits_i));
      rsh_d  = '0;
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rsh_d  = lsb_q ? {miso_i, rsh_q[W-1:1]} : {rsh_q[W-2:0], miso_i};
      end else begin
        sclk_d = 1'b0;
        left_d = left_q - CW'(1);
        if (left_q == CW'(1)) busy_d = 1'b0;
        else                  tsh_d  = lsb_q ? (tsh_q >> 1) : (tsh_q << 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      lsb_q  <= 1'b0;
      left_q <= '0;
      nb_q   <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      lsb_q  <= lsb_d;
      left_q <= left_d;
      nb_q   <= nb_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = busy_q && (lsb_q ? tsh_q[0] : tsh_q[W-1]);
  assign done_o = tick && sclk_q && (left_q == CW'(1));
  assign rx_o   = lsb_q ? (rsh_q >> (CW'(W) - nb_q)) : rsh_q;

endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_valid_i,
  input  logic              tx_is_cmd_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);

  localparam int W  = WORD_W;
  localparam int CW = $clog2(W) + 1;

  spi_st_e         state_q, state_d;
  spi_cfg_t        cfg_q, cfg_d;
  logic            cs_n_q, cs_n_d;
  logic            held_q, held_d;
  logic [FS_W-1:0] left_q, left_d;

  logic [CW-1:0]   chunk_bits;
  logic            last_chunk;
  logic            rx_full, rx_ok, rx_push;
  logic            eng_start, eng_done;
  logic [W-1:0]    eng_word, eng_rx, rx_word;

  assign last_chunk = (left_q <= FS_W'(W));
  assign chunk_bits = last_chunk ? left_q[CW-1:0] : CW'(W);
  assign rx_ok      = cfg_q.rx_mask || !rx_full;
  assign eng_word   = cfg_q.tx_mask ? '0 : (cfg_q.swap ? bswap32(tx_data_i) : tx_data_i);
  assign rx_word    = cfg_q.swap ? bswap32(eng_rx) : eng_rx;

  always_comb begin
    state_d    = state_q;
    cfg_d      = cfg_q;
    cs_n_d     = cs_n_q;
    held_d     = held_q;
    left_d     = left_q;
    tx_ready_o = 1'b0;
    eng_start  = 1'b0;
    rx_push    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tx_ready_o = 1'b1;
        if (tx_valid_i && tx_is_cmd_i) begin
          cfg_d = cmd_decode(tx_data_i);
          if (held_q && !cfg_d.contg) begin
            cs_n_d = 1'b1;
            held_d = 1'b0;
          end else begin
            cs_n_d  = 1'b0;
            held_d  = 1'b0;
            left_d  = cfg_d.fsize;
            state_d = ST_WORD;
          end
        end
      end
      ST_WORD: begin
        tx_ready_o = !cfg_q.tx_mask && rx_ok && !tx_is_cmd_i;
        if (rx_ok && (cfg_q.tx_mask || (tx_valid_i && !tx_is_cmd_i))) begin
          eng_start = 1'b1;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (eng_done) begin
          rx_push = !cfg_q.rx_mask;
          left_d  = left_q - FS_W'(chunk_bits);
          if (last_chunk) begin
            state_d = ST_IDLE;
            if (cfg_q.hold) held_d = 1'b1;
            else            cs_n_d = 1'b1;
          end else begin
            state_d = ST_WORD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= CFG_RST;
      cs_n_q  <= 1'b1;
      held_q  <= 1'b0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      cs_n_q  <= cs_n_d;
      held_q  <= held_d;
      left_q  <= left_d;
    end
  end

  assign cs_n_o = cs_n_q;

  spi_shift_eng #(.W(W), .DIV_W(DIV_W)) eng_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_i   (div_i),
    .start_i (eng_start),
    .word_i  (eng_word),
    .nbits_i (chunk_bits),
    .lsb_i   (cfg_q.lsb),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  spi_rx_fifo #(.W(W), .DEPTH(RX_DEPTH)) rxq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_push),
    .data_i  (rx_word),
    .full_o  (rx_full),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .ready_i (rx_ready_i)
  );

endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic        cs_n_o,
  input logic        tx_valid_i,
  input logic        tx_ready_o,
  input logic        rx_valid_o,
  input logic        rx_ready_i,
  input logic [31:0] rx_data_o,
  input logic        rx_push,
  input logic        rx_full,
  input logic        frame_busy,
  input logic        cfg_tx_mask
);

  a_r11_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  a_r11_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r13_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  a_r6_no_pop_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && cfg_tx_mask) |-> !(tx_valid_i && tx_ready_o));

endmodule

bind spi_cmd_master spi_cmd_master_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_n_o      (cs_n_o),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ready_i  (rx_ready_i),
  .rx_data_o   (rx_data_o),
  .rx_push     (rx_push),
  .rx_full     (rx_full),
  .frame_busy  (state_q != spi_cmd_pkg::ST_IDLE),
  .cfg_tx_mask (cfg_q.tx_mask)
);

// File: tb/spi_cmd_master_tb_top.sv
module spi_cmd_master_tb_top;

  typedef struct packed {
    logic [31:0] cmd;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [63:0] miso;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0008, 32'h0000_00A5, 32'h0,          64'h0000_0000_0000_003C},
    '{32'h0001_0008, 32'h0000_01C3, 32'h0,          64'h0000_0000_0000_00B1},
    '{32'h0002_0010, 32'h1122_3344, 32'h0,          64'h0000_0000_0000_9E37},
    '{32'h0003_000C, 32'hCAFE_1234, 32'h0,          64'h0000_0000_0000_0A5F},
    '{32'h0000_0003, 32'h0000_005A, 32'h0,          64'h0000_0000_0000_00E1},
    '{32'h0000_0028, 32'hDEAD_BEEF, 32'h0000_0077,  64'h0000_00C4_1357_9BDF},
    '{32'h0004_0008, 32'h0000_0066, 32'h0,          64'h0000_0000_0000_00FF},
    '{32'h0008_0010, 32'h0,          32'h0,          64'h0000_0000_0000_B00C},
    '{32'h0001_0020, 32'h8001_F00F, 32'h0,          64'h0000_0000_2468_ACE1},
    '{32'h0003_0028, 32'h0102_0304, 32'h0000_00A9,  64'h0000_005D_F00D_1234}
  };

  logic        clk, rst_n;
  logic [7:0]  div;
  logic        tx_valid, tx_is_cmd, tx_ready;
  logic [31:0] tx_data;
  logic        rx_valid, rx_ready;
  logic [31:0] rx_data;
  logic        sclk, mosi, miso, cs_n;

  int tests = 0;
  int fails = 0;
  int nbit = 0;
  int base = 0;
  int cyc = 0;
  int cs_rises = 0;
  logic [63:0] pat = '0;
  logic mosi_log [0:4095];
  logic exp_mosi [0:127];
  logic [31:0] exp_rx [0:3];
  int exp_nrx, exp_nbits;
  int mk;

  spi_cmd_master dut_i (
    .clk(clk), .rst_n(rst_n), .div_i(div),
    .tx_valid_i(tx_valid), .tx_is_cmd_i(tx_is_cmd), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ready_i(rx_ready),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge cs_n) cs_rises <= cs_rises + 1;
  always @(posedge sclk) begin
    mosi_log[nbit] <= mosi;
    nbit <= nbit + 1;
  end

  assign mk   = nbit - base;
  assign miso = (mk >= 0 && mk < 64) ? pat[mk[5:0]] : 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic push(input logic c, input logic [31:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_is_cmd = c; tx_data = d;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    tx_valid = 1'b0; tx_is_cmd = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    d = rx_data; rx_ready = 1'b1;
    @(posedge clk); #1;
    rx_ready = 1'b0;
  endtask

  // Model of R2/R3/R4/R5/R6/R8 for one frame starting at stream offset 0
  task automatic build_exp(input logic [31:0] cmd, input logic [31:0] d0, input logic [31:0] d1);
    int n, left, pos, k, b;
    logic [31:0] w, r;
    n = (cmd[11:0] < 12'd8) ? 8 : int'(cmd[11:0]);
    left = n; pos = 0; k = 0; exp_nrx = 0; exp_nbits = n;
    while (left > 0) begin
      b = (left > 32) ? 32 : left;
      w = cmd[19] ? 32'h0 : ((k == 0) ? d0 : d1);
      if (cmd[17]) w = bsw(w);
      r = '0;
      for (int i = 0; i < b; i++) begin
        exp_mosi[pos+i] = cmd[16] ? w[i] : w[b-1-i];
        if (cmd[16]) r[i] = pat[pos+i];
        else         r[b-1-i] = pat[pos+i];
      end
      if (cmd[17]) r = bsw(r);
      if (!cmd[18]) begin exp_rx[exp_nrx] = r; exp_nrx++; end
      pos += b; left -= b; k++;
    end
  endtask

  task automatic cmp_stream(input string req, input int start);
    int bad = 0;
    for (int i = 0; i < exp_nbits; i++)
      if (mosi_log[start+i] !== exp_mosi[i]) bad++;
    chk(nbit - start == exp_nbits, {req, " bit count"}, 64'(nbit - start), 64'(exp_nbits));
    chk(bad == 0, {req, " mosi stream"}, 64'(bad), 64'd0);
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 8: return "R3";
      2, 3:    return "R4";
      4:       return "R2";
      5, 9:    return "R8";
      6:       return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, t1, r0, nv;
    rst_n = 1'b0; div = 8'd1;
    tx_valid = 1'b0; tx_is_cmd = 1'b0; tx_data = '0; rx_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0 && rx_valid === 1'b0, "R1 reset outputs",
        {60'd0, cs_n, sclk, mosi, rx_valid}, 64'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      base = nbit; pat = VECS[v].miso;
      build_exp(VECS[v].cmd, VECS[v].d0, VECS[v].d1);
      nv = VECS[v].cmd[19] ? 0 : (exp_nbits + 31) / 32;
      push(1'b1, VECS[v].cmd);
      chk(cs_n === 1'b0, {tag_of(v), " cs low after command (R2)"}, 64'(cs_n), 64'd0);
      if (nv > 0) push(1'b0, VECS[v].d0);
      if (nv > 1) push(1'b0, VECS[v].d1);
      wait (cs_n == 1'b1);
      @(negedge clk);
      cmp_stream(tag_of(v), base);
      for (int j = 0; j < exp_nrx; j++) begin
        chk(rx_valid === 1'b1, {tag_of(v), " rx entry present"}, 64'(rx_valid), 64'd1);
        pop(d);
        chk(d === exp_rx[j], {tag_of(v), " rx word"}, 64'(d), 64'(exp_rx[j]));
      end
      @(negedge clk);
      chk(rx_valid === 1'b0, {tag_of(v), " no extra rx entry (R5)"}, 64'(rx_valid), 64'd0);
    end

    // R7: held transfer, continuing command, closing command; R13 hold
    base = nbit; pat = 64'h0000_0000_0000_5AC3; r0 = cs_rises;
    push(1'b1, 32'h0010_0008); push(1'b0, 32'h81);
    wait (nbit - base == 8); repeat (12) @(negedge clk);
    chk(cs_n === 1'b0, "R7 cs held after continuous frame", 64'(cs_n), 64'd0);
    push(1'b1, 32'h0030_0008); push(1'b0, 32'h42);
    wait (nbit - base == 16); repeat (12) @(negedge clk);
    chk(cs_n === 1'b0 && cs_rises == r0, "R7 cs held across continuing frame", 64'(cs_rises - r0), 64'd0);
    push(1'b1, 32'h0000_0008); repeat (6) @(negedge clk);
    chk(cs_n === 1'b1 && cs_rises == r0 + 1, "R7 closing command raises cs", 64'(cs_rises - r0), 64'd1);
    chk(nbit - base == 16, "R7 closing command opens no frame", 64'(nbit - base), 64'd16);
    exp_nbits = 16;
    for (int i = 0; i < 8; i++) begin exp_mosi[i] = 8'h81 >> (7 - i); exp_mosi[8+i] = 8'h42 >> (7 - i); end
    cmp_stream("R7", base);
    d = rx_data; repeat (10) @(negedge clk);
    chk(rx_valid === 1'b1 && rx_data === d, "R13 rx word held without ready", 64'(rx_data), 64'(d));
    pop(d); chk(d === 32'hC3, "R7 first held rx word", 64'(d), 64'hC3);
    pop(d); chk(d === 32'h5A, "R7 second held rx word", 64'(d), 64'h5A);

    // R9: transmit starvation in a 40-bit frame
    base = nbit; pat = 64'h0;
    push(1'b1, 32'h0000_0028); push(1'b0, 32'h1234_5678);
    wait (nbit - base == 32); repeat (40) @(negedge clk);
    chk(nbit - base == 32 && cs_n === 1'b0 && sclk === 1'b0, "R9 stall with cs low and sclk low",
        64'(nbit - base), 64'd32);
    push(1'b0, 32'h0000_00C6);
    wait (cs_n == 1'b1); @(negedge clk);
    build_exp(32'h28, 32'h1234_5678, 32'hC6);
    cmp_stream("R9", base);
    pop(d); pop(d);

    // R10: receive queue full blocks the next piece
    base = nbit; pat = 64'h0;
    for (int f = 0; f < 4; f++) begin push(1'b1, 32'h8); push(1'b0, 32'h11 * (f + 1)); end
    push(1'b1, 32'h0008_0008);
    repeat (60) @(negedge clk);
    chk(nbit - base == 32 && cs_n === 1'b0, "R10 shifting paused while rx full", 64'(nbit - base), 64'd32);
    pop(d);
    wait (cs_n == 1'b1); @(negedge clk);
    chk(nbit - base == 40, "R10 frame resumes after pop", 64'(nbit - base), 64'd40);
    t0 = 0;
    for (int j = 0; j < 4; j++) if (rx_valid) begin pop(d); t0++; end
    chk(t0 == 4, "R10 four entries remain after one pop", 64'(t0), 64'd4);

    // R12: data word with no open frame is dropped
    base = nbit; pat = 64'h0;
    push(1'b0, 32'h0000_00FF);
    push(1'b1, 32'h8); push(1'b0, 32'h0F);
    wait (cs_n == 1'b1); @(negedge clk);
    build_exp(32'h8, 32'h0F, 32'h0);
    cmp_stream("R12", base);
    pop(d);

    // R11: SCLK period with div = 3
    div = 8'd3; base = nbit;
    push(1'b1, 32'h8); push(1'b0, 32'h3C);
    @(posedge sclk); t0 = cyc;
    @(posedge sclk); t1 = cyc;
    chk(t1 - t0 == 8, "R11 sclk period 2*(div+1)", 64'(t1 - t0), 64'd8);
    wait (cs_n == 1'b1); @(negedge clk);
    chk(sclk === 1'b0, "R11 sclk low when idle", 64'(sclk), 64'd0);
    pop(d);
    div = 8'd1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule